// File: doc/BRIEF.md
# Periodic Trigger Pulse Generator

This block produces a repeating trigger pulse whose period is set in units of the 8 ns time-base tick. One clock cycle of `clk` is one tick. The period is a 32-bit tick count, written through a small 16-bit write port as two halves. A third register holds a picosecond compensation value, below 8000, for the part of the wanted period that is not a whole number of ticks. An accumulator adds this value once per period. Each time the sum reaches 8000 ps it drops 8000 ps and makes that period one tick longer. Over many periods the average period therefore equals the programmed ticks plus the compensation.

A configuration register starts and stops generation. It also selects one-shot or continuous operation and the polarity of the trigger pin. Besides the pin, the block drives a one-cycle internal strobe that other logic can use to mark a period boundary. A one-second output comes from a period of 125,000,000 ticks with zero compensation.

Top module: `trig_pulse_gen`

## Requirements
- R1: After reset, both outputs are low, all registers are zero, and generation is stopped. Starting the block without writing the period gives the zero-period behaviour of R2.
- R2: Write address 0 is the configuration: bit 0 enables, bit 1 selects one-shot and bit 12 inverts the pin. Address 1 is the low half of the period in ticks and address 2 the high half. Address 3 is the compensation in ps. A period value of 0 acts as 1 tick.
- R3: In continuous mode with zero compensation, `trig_strobe` is high for exactly one cycle every P cycles.
- R4: With compensation C, period n after enabling (n counting from 0) lasts P + floor((n+1)·C/8000) − floor(n·C/8000) ticks.
- R5: A compensation write of 8000 or more is ignored, and the previously stored value stays in force.
- R6: Writing the configuration with bit 0 set restarts generation, even when it is already running. The strobe is high in the cycle after the write edge, the count restarts from zero and the accumulator is cleared.
- R7: Writing the configuration with bit 0 clear stops generation. No strobe appears from the cycle after the write.
- R8: Period and compensation writes made while running do not alter the period in progress. They apply from the next period boundary.
- R9: In one-shot mode, exactly one strobe is produced after enabling. Generation then stops until the block is enabled again.
- R10: `trig_out` equals `trig_strobe` when bit 12 is clear and its inverse when bit 12 is set, so the pin idles high when inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock, one 8 ns tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 config, 1 period low, 2 period high, 3 compensation) |
| wr_data | input | 16 | Register write data |
| trig_out | output | 1 | Trigger pin, polarity set by config bit 12 |
| trig_strobe | output | 1 | One-cycle internal strobe at each period start |

## Verification
Several invariants are checked on every cycle by the assertions:
- The picosecond accumulator stays below 8000.
- The tick counter stays inside the latched period length.
- The latched length holds steady within a period.
- A strobe follows every restart and every continuous-mode boundary.
- Nothing fires after a stop or after a one-shot ends.

Some behaviour can only be shown by the bench's scenarios. This covers the exact spacing of pulses as the compensation pattern varies, the rejection of out-of-range compensation, the deferred effect of mid-period writes and the pin polarity. The bench compares every cycle against an arithmetic model of the period sequence.

// File: rtl/trig_pkg.sv
// Package: shared constants for the periodic trigger generator.
// Assumes a 2-bit register address space and a 16-bit write bus.
package trig_pkg;
    localparam logic [1:0] ADDR_CFG    = 2'd0;
    localparam logic [1:0] ADDR_PER_LO = 2'd1;
    localparam logic [1:0] ADDR_PER_HI = 2'd2;
    localparam logic [1:0] ADDR_COMP   = 2'd3;

    localparam int CFG_ENABLE_BIT  = 0;
    localparam int CFG_ONESHOT_BIT = 1;
    localparam int CFG_INVERT_BIT  = 12;

    localparam int DEFAULT_TICK_PS = 8000;
endpackage

// File: rtl/trig_regs.sv
// Module: trig_regs
// Holds the configuration, the two period halves and the compensation value.
// Turns each configuration write into a start or a stop request.
// Assumes one write per cycle and that a compensation value of TICK_PS or
// more is invalid, so such a write is dropped.
module trig_regs
    import trig_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COMP_W  = 16,
    parameter int TICK_PS = DEFAULT_TICK_PS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  start_req,
    output logic                  stop_req,
    output logic                  oneshot,
    output logic                  invert,
    output logic [2*DATA_W-1:0]   period,
    output logic [COMP_W-1:0]     comp
);
    localparam logic [DATA_W-1:0] TICK_LIM = DATA_W'(TICK_PS);
    localparam int                NHALF    = 2;

    logic [DATA_W-1:0] half_q [NHALF];
    logic              cfg_wr;

    assign cfg_wr    = wr_en && (wr_addr == ADDR_CFG);
    assign start_req = cfg_wr && wr_data[CFG_ENABLE_BIT];
    assign stop_req  = cfg_wr && !wr_data[CFG_ENABLE_BIT];

    // Purpose: store the mode and polarity bits on each configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oneshot <= 1'b0;
            invert  <= 1'b0;
        end else if (cfg_wr) begin
            oneshot <= wr_data[CFG_ONESHOT_BIT];
            invert  <= wr_data[CFG_INVERT_BIT];
        end
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam logic [1:0] HALF_ADDR = ADDR_PER_LO + 2'(h);
        // Purpose: store one 16-bit half of the period tick count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_q[h] <= '0;
            else if (wr_en && (wr_addr == HALF_ADDR))
                half_q[h] <= wr_data;
        end
    end

    assign period = {half_q[1], half_q[0]};

    // Purpose: store the compensation value, dropping out-of-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            comp <= '0;
        else if (wr_en && (wr_addr == ADDR_COMP) && (wr_data < TICK_LIM))
            comp <= wr_data[COMP_W-1:0];
    end

    // R5: the stored compensation never reaches a full tick.
    a_r5_comp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        comp < COMP_W'(TICK_PS));
endmodule

// File: rtl/trig_frac_acc.sv
// Module: trig_frac_acc
// Picosecond remainder accumulator. Its output says whether the period
// being loaded gets one extra tick. The state advances only when the
// counter loads a new period. A clear (at enable) starts the sum from zero.
// Assumes comp < TICK_PS.
module trig_frac_acc #(
    parameter int COMP_W  = 16,
    parameter int TICK_PS = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [COMP_W-1:0] comp,
    output logic              extra
);
    localparam int              SUM_W = COMP_W + 1;
    localparam logic [SUM_W-1:0] TICK = SUM_W'(TICK_PS);

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;

    // Purpose: form the candidate sum for the period being loaded.
    always_comb begin
        base  = clear ? '0 : acc_q;
        sum   = base + SUM_W'(comp);
        extra = (sum >= TICK);
    end

    // Purpose: keep the remainder below one tick after each period load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (load)
            acc_q <= extra ? (sum - TICK) : sum;
    end

    // R4: the stored remainder is always less than one tick.
    a_r4_acc_below_tick: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < TICK);
    // R4: with no compensation, no period is ever lengthened.
    a_r4_no_extra_without_comp: assert property (@(posedge clk) disable iff (!rst_n)
        (load && comp == '0) |-> !extra);
endmodule

// File: rtl/trig_period_ctr.sv
// Module: trig_period_ctr
// Tick counter and run state. It latches the length of each period at its
// start: the programmed ticks (0 acts as 1) plus the accumulator's extra
// tick. It raises the strobe on the first tick of each period. A start
// request always wins over a stop or a boundary in the same cycle.
module trig_period_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] period,
    input  logic             extra,
    output logic             load_acc,
    output logic             strobe
);
    localparam int LEN_W = CNT_W + 1;

    logic             running_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_next;
    logic [CNT_W-1:0] per_eff;
    logic             boundary;

    // Purpose: compute the length of the period about to start.
    always_comb begin
        per_eff  = (period == '0) ? CNT_W'(1) : period;
        len_next = LEN_W'(per_eff) + LEN_W'(extra);
        boundary = running_q && (cnt_q == len_q - LEN_W'(1));
        load_acc = start || (boundary && !oneshot && !stop);
    end

    // Purpose: advance the tick count, reload at boundaries, handle start/stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            len_q     <= LEN_W'(1);
        end else if (start) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
            len_q     <= len_next;
        end else if (stop) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (boundary) begin
            cnt_q <= '0;
            if (oneshot)
                running_q <= 1'b0;
            else
                len_q <= len_next;
        end else if (running_q) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign strobe = running_q && (cnt_q == '0);

    // R2: the count never leaves the latched period.
    a_r2_cnt_in_len: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cnt_q < len_q));
    // R6: a start request yields a strobe on the next cycle.
    a_r6_restart_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> strobe);
    // R7: a stop without a start silences the strobe next cycle.
    a_r7_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !strobe);
    // R3: a continuous-mode boundary is followed by a strobe.
    a_r3_boundary_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !oneshot && !start && !stop) |=> strobe);
    // R9: a one-shot boundary ends the run.
    a_r9_oneshot_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && oneshot && !start) |=> !running_q);
    // R8: the latched length is held for the whole period.
    a_r8_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !boundary && !start) |=> $stable(len_q));
endmodule

// File: rtl/trig_pulse_gen.sv
// Module: trig_pulse_gen (top)
// Periodic trigger pulse generator: register file, picosecond accumulator
// and tick counter. One clk cycle is one time-base tick. Assumes the write
// port is used in the clk domain.
module trig_pulse_gen
    import trig_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COMP_W  = 16,
    parameter int TICK_PS = DEFAULT_TICK_PS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              trig_out,
    output logic              trig_strobe
);
    localparam int CNT_W = 2 * DATA_W;

    logic             start_req;
    logic             stop_req;
    logic             oneshot;
    logic             invert;
    logic [CNT_W-1:0] period;
    logic [COMP_W-1:0] comp;
    logic             extra;
    logic             load_acc;
    logic             strobe;

    trig_regs #(.DATA_W(DATA_W), .COMP_W(COMP_W), .TICK_PS(TICK_PS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_req(start_req), .stop_req(stop_req),
        .oneshot(oneshot), .invert(invert), .period(period), .comp(comp)
    );

    trig_frac_acc #(.COMP_W(COMP_W), .TICK_PS(TICK_PS)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load_acc), .clear(start_req),
        .comp(comp), .extra(extra)
    );

    trig_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .start(start_req), .stop(stop_req),
        .oneshot(oneshot), .period(period), .extra(extra),
        .load_acc(load_acc), .strobe(strobe)
    );

    // Purpose: apply the selected polarity to the pin.
    always_comb begin
        trig_strobe = strobe;
        trig_out    = invert ? !strobe : strobe;
    end
endmodule

// File: tb/test_trig_pulse_gen.sv
module test_trig_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        trig_out;
    logic        trig_strobe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    trig_pulse_gen i_trig_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_out(trig_out), .trig_strobe(trig_strobe)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step_expect(input bit exp, input bit inv, input string req);
        @(posedge clk); @(negedge clk);
        chk(trig_strobe == exp, req, trig_strobe, exp);
        chk(trig_out == (exp ^ inv), "R10", trig_out, exp ^ inv);
    endtask

    function automatic longint plen(input longint p, input longint c, input longint n);
        return ((p == 0) ? 1 : p) + ((n + 1) * c) / 8000 - (n * c) / 8000;
    endfunction

    // Start with the given setup; returns at the cycle the first strobe is due.
    task automatic start_cfg(input longint p, input longint c, input bit os, input bit inv);
        wr(2'd1, 16'(p));
        wr(2'd2, 16'(p >> 16));
        wr(2'd3, 16'(c));
        wr(2'd0, {3'b000, inv, 10'd0, os, 1'b1});
    endtask

    task automatic check_run(input longint p, input longint c, input int ncyc,
                             input bit os, input bit inv, input string req);
        longint next_t = 0;
        longint n = 0;
        for (int t = 0; t < ncyc; t++) begin
            bit exp;
            if (t > 0) begin @(posedge clk); @(negedge clk); end
            exp = (t == next_t) && !(os && n > 0);
            if (t == next_t) begin next_t += plen(p, c, n); n++; end
            chk(trig_strobe == exp, req, trig_strobe, exp);
            chk(trig_out == (exp ^ inv), "R10", trig_out, exp ^ inv);
        end
    endtask

    initial begin
        #(190000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        longint pv [5] = '{1, 2, 3, 5, 0};
        longint cv [5] = '{0, 1000, 2500, 4000, 7999};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low in reset
        chk(trig_strobe == 1'b0, "R1", trig_strobe, 0);
        chk(trig_out == 1'b0, "R1", trig_out, 0);
        rst_n = 1'b1;
        step_expect(1'b0, 1'b0, "R1");
        // R1/R2: enable with reset registers -> period 0 acts as 1 tick
        wr(2'd0, 16'h0001);
        check_run(0, 0, 6, 1'b0, 1'b0, "R1");

        // R3/R4: sweep period and compensation
        foreach (pv[i]) begin
            foreach (cv[j]) begin
                start_cfg(pv[i], cv[j], 1'b0, 1'b0);
                check_run(pv[i], cv[j], 48, 1'b0, 1'b0, (cv[j] == 0) ? "R3" : "R4");
            end
        end

        // R5: out-of-range compensation writes ignored
        start_cfg(2, 0, 1'b0, 1'b0);
        wr(2'd3, 16'd9000);
        wr(2'd3, 16'd8000);
        wr(2'd0, 16'h0001);
        check_run(2, 0, 40, 1'b0, 1'b0, "R5");

        // R6: restart while running
        start_cfg(5, 0, 1'b0, 1'b0);
        step_expect(1'b0, 1'b0, "R6");
        step_expect(1'b0, 1'b0, "R6");
        wr(2'd0, 16'h0001);
        check_run(5, 0, 12, 1'b0, 1'b0, "R6");

        // R7: stop
        start_cfg(3, 0, 1'b0, 1'b0);
        wr(2'd0, 16'h0000);
        for (int k = 0; k < 10; k++) step_expect(1'b0, 1'b0, "R7");

        // R8: period change applies at next boundary
        start_cfg(4, 0, 1'b0, 1'b0);
        wr(2'd1, 16'd7);
        chk(trig_strobe == 1'b0, "R8", trig_strobe, 0);
        step_expect(1'b0, 1'b0, "R8");
        step_expect(1'b0, 1'b0, "R8");
        step_expect(1'b1, 1'b0, "R8");
        for (int k = 0; k < 6; k++) step_expect(1'b0, 1'b0, "R8");
        step_expect(1'b1, 1'b0, "R8");

        // R9: one-shot
        start_cfg(3, 0, 1'b1, 1'b0);
        check_run(3, 0, 20, 1'b1, 1'b0, "R9");
        wr(2'd0, 16'h0003);
        check_run(3, 0, 10, 1'b1, 1'b0, "R9");

        // R10: inverted polarity with compensation
        start_cfg(4, 3000, 1'b0, 1'b1);
        check_run(4, 3000, 60, 1'b0, 1'b1, "R10");
        wr(2'd0, 16'h1000);
        step_expect(1'b0, 1'b1, "R10");

        // R2: high half of the period
        start_cfg(32'h0001_0000, 0, 1'b0, 1'b0);
        check_run(32'h0001_0000, 0, 65540, 1'b0, 1'b0, "R2");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule